// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Target with Self-Advancing Pointer

The block is a target on a two-wire serial bus (I2C-style START/STOP, 8-bit bytes, 9th-clock acknowledge) that answers one fixed 7-bit device address. Behind it is a 256-byte array. When a write transaction begins, the first byte after the address selects a location: it loads an internal location pointer. Any further bytes in that transaction are stored starting at that location. When a read transaction begins, bytes come back starting at the pointer's current value. After each data byte moves in either direction, the pointer advances by one, and it keeps its value from one transaction to the next. Because of this, a host can set the pointer with a short write and then read from that location with a repeated START.

Both bus lines are sampled with the system clock. They first pass through a synchronizer, and edge detection follows. The data line is open-drain, so the block reports only when it wants the line pulled low. There is a build option that presets each memory location to its own index.

The control state machine has these states:
- `ST_IDLE`: waiting for a START.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_PTR`: receiving the pointer byte.
- `ST_PTR_ACK`: acknowledging the pointer byte.
- `ST_WDATA`: receiving a data byte.
- `ST_WDATA_ACK`: acknowledging a data byte.
- `ST_RDATA`: sending a data byte.
- `ST_RACK`: sampling the host's acknowledge.
- `ST_WAIT`: line released until the next START.

The transitions are:
- Any state goes to `ST_ADDR` on START, and to `ST_IDLE` on STOP.
- `ST_ADDR` goes to `ST_ADDR_ACK` when the address matches, or to `ST_WAIT` when it does not.
- `ST_ADDR_ACK` goes to `ST_PTR` for a write, or to `ST_RDATA` for a read.
- `ST_PTR` goes to `ST_PTR_ACK`, which goes to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WDATA_ACK`, which returns to `ST_WDATA`.
- `ST_RDATA` goes to `ST_RACK`.
- `ST_RACK` returns to `ST_RDATA` on a host ACK, or goes to `ST_WAIT` on a host NACK.

Each move between byte and acknowledge states happens on a falling SCL edge.

Top module: `i2cmem_slave`

## Requirements
- R1: Address matching.
  - The block acknowledges the address byte when its upper 7 bits equal `DEV_ADDR`, whose default is 7'b1010000. Acknowledging means pulling SDA low through the 9th SCL pulse.
  - Bit 0 of the address byte selects the direction: 0 is write, 1 is read.
  - If the address differs, the block never pulls SDA until the next START, including during the acknowledge slot.
- R2: In a write transaction, the first byte after the address loads the pointer, and the block acknowledges that byte.
- R3: Each later byte in a write transaction is acknowledged and stored at the location the pointer holds. The pointer then advances by one.
- R4: Read data and pointer advance.
  - A read transaction returns the byte at the pointer, most significant bit first. The pointer advances by one after each byte sent.
  - When the host acknowledges, the next location follows.
- R5: The pointer keeps its value across STOP and repeated START, so a read returns data from where the last write left the pointer.
- R6: The pointer wraps from 0xFF to 0x00 in both writes and reads.
- R7: If the host answers NACK after a read byte, the block releases SDA and drives nothing until the next START.
- R8: With `PRESET` = 1, every location N holds the value N after reset.
- R9: A START seen at any point, even in the middle of a byte, discards the partial byte and restarts the bit count for a new address byte. The partial byte is never stored.
- R10: A write transaction that carries only the pointer byte changes the pointer and leaves the memory unchanged.
- R11: While reset is applied and after a STOP, the block does not pull SDA low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| sda_pull_o | output | 1 | 1 = pull the data line low; 0 = release it |

## Verification
Two things can fall on the same byte boundary. In one case, a START condition arrives while a data byte is still being shifted in; the bit count must restart and the store of that byte must be suppressed in the same step. In the other case, the pointer increment coincides with the wrap at 0xFF. The bench provokes the first case by issuing a repeated START after three bits of a data byte. It judges the outcome by reading back the pointed location, which must still hold its old value, and by checking that the new address is acknowledged. It provokes the wrap by writing two bytes from location 0xFF, then reads both back across the 0xFF to 0x00 boundary.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } slv_state_e;
endpackage

// File: rtl/i2cmem_line_cond.sv
module i2cmem_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_d, sda_d, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_sh[SYNC_STAGES-1];
            sda_d  <= sda_sh[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_sh[SYNC_STAGES-1];
    assign sda_s     = sda_sh[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cmem_store.sv
module i2cmem_store #(
    parameter int PTR_W  = 8,
    parameter bit PRESET = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [7:0]       rdata
);
    localparam int DEPTH = 1 << PTR_W;

    logic [7:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= PRESET ? 8'(g) : 8'h00;
            else if (we && (waddr == PTR_W'(g)))
                mem[g] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/i2cmem_slave.sv
module i2cmem_slave
    import i2cmem_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1010000,
    parameter int         PTR_W       = 8,
    parameter bit         PRESET      = 1'b1,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    slv_state_e state, nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh;
    logic [PTR_W-1:0]  ptr;
    logic [7:0]        rdata;
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic rw_q, mack, sda_pull, mem_we, addr_hit, byte_done;

    i2cmem_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cmem_store #(.PTR_W(PTR_W), .PRESET(PRESET)) u_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(ptr),
        .wdata(rx_sh), .raddr(ptr), .rdata(rdata)
    );

    assign addr_hit  = (rx_sh[7:1] == DEV_ADDR);
    assign byte_done = scl_fall && (bit_cnt == CNT_FULL);
    assign mem_we    = (state == ST_WDATA) && byte_done && !start_det && !stop_det;

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_det)       nxt = ST_IDLE;
        else if (start_det) nxt = ST_ADDR;
        else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_WAIT;
                ST_ADDR_ACK:  if (scl_fall) nxt = rw_q ? ST_RDATA : ST_PTR;
                ST_PTR:       if (byte_done) nxt = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (byte_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (scl_fall && bit_cnt == CNT_LAST) nxt = ST_RACK;
                ST_RACK:      if (scl_fall) nxt = mack ? ST_RDATA : ST_WAIT;
                ST_WAIT:      nxt = ST_WAIT;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and line drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            ptr      <= '0;
            sda_pull <= 1'b0;
            rw_q     <= 1'b0;
            mack     <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
        end else begin
            if (scl_rise) begin
                rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                if (state inside {ST_ADDR, ST_PTR, ST_WDATA}) bit_cnt <= bit_cnt + 1'b1;
                if (state == ST_RACK) mack <= ~sda_s;
            end
            if (scl_fall) begin
                unique case (state)
                    ST_ADDR: if (bit_cnt == CNT_FULL) begin
                        bit_cnt <= '0;
                        if (addr_hit) begin
                            sda_pull <= 1'b1;
                            rw_q     <= rx_sh[0];
                        end
                    end
                    ST_ADDR_ACK: begin
                        sda_pull <= 1'b0;
                        bit_cnt  <= '0;
                        if (rw_q) begin
                            tx_sh    <= rdata;
                            sda_pull <= ~rdata[7];
                        end
                    end
                    ST_PTR: if (bit_cnt == CNT_FULL) begin
                        ptr      <= rx_sh[PTR_W-1:0];
                        sda_pull <= 1'b1;
                        bit_cnt  <= '0;
                    end
                    ST_WDATA: if (bit_cnt == CNT_FULL) begin
                        ptr      <= ptr + 1'b1;
                        sda_pull <= 1'b1;
                        bit_cnt  <= '0;
                    end
                    ST_PTR_ACK, ST_WDATA_ACK: sda_pull <= 1'b0;
                    ST_RDATA: if (bit_cnt == CNT_LAST) begin
                        sda_pull <= 1'b0;
                        ptr      <= ptr + 1'b1;
                        bit_cnt  <= '0;
                    end else begin
                        tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                        sda_pull <= ~tx_sh[BYTE_W-2];
                        bit_cnt  <= bit_cnt + 1'b1;
                    end
                    ST_RACK: if (mack) begin
                        tx_sh    <= rdata;
                        sda_pull <= ~rdata[7];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull_o = sda_pull;

    assert_addr_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> sda_pull_o);
    assert_wr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA_ACK && $past(state) == ST_WDATA) |-> ptr == $past(ptr) + 1'b1);
    assert_rd_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK && $past(state) == ST_RDATA) |-> ptr == $past(ptr) + 1'b1);
    assert_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !sda_pull_o);
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bit_cnt == '0));
    assert_stop_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_pull_o));
endmodule

// File: tb/i2cmem_slave_tb_top.sv
module i2cmem_slave_tb_top;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_line;

    assign sda_line = sda_m & ~sda_pull;

    always #10 clk = ~clk;

    i2cmem_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull)
    );

    typedef struct {
        string      req;
        logic [7:0] val;
    } item_t;

    item_t      exp_q[$];
    int         checks = 0;
    int         errors = 0;
    logic [7:0] obs_val;
    event       obs_ev;

    // monitor: pops expected items as results appear
    initial begin
        item_t it;
        forever begin
            @(obs_ev);
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected result actual %h expected none", obs_val);
            end else begin
                it = exp_q.pop_front();
                if (obs_val !== it.val) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", it.req, obs_val, it.val);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_now(input string r, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic observe(input logic [7:0] v);
        obs_val = v;
        ->obs_ev;
        tick(1);
    endtask

    task automatic m_start;
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic m_stop;
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic m_wbit(input logic b);
        sda_m = b;  tick(Q);
        scl = 1'b1; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic m_rbit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        b = sda_line;
        scl = 1'b0;   tick(Q);
    endtask

    // driver: pushes the expected ack (0 = pulled low) then shifts the byte
    task automatic m_wbyte(input logic [7:0] d, input string r, input logic exp_ack);
        logic a;
        exp_q.push_back('{r, {7'b0, exp_ack}});
        for (int i = 7; i >= 0; i--) m_wbit(d[i]);
        m_rbit(a);
        observe({7'b0, a});
    endtask

    task automatic m_rbyte(input logic nack, input string r, input logic [7:0] exp);
        logic [7:0] d;
        logic b;
        exp_q.push_back('{r, exp});
        for (int i = 7; i >= 0; i--) begin
            m_rbit(b);
            d[i] = b;
        end
        m_wbit(nack);
        observe(d);
    endtask

    initial begin
        tick(5);
        check_now("R11", {7'b0, sda_pull}, 8'h00);
        rst_n = 1'b1;
        tick(5);

        // R8 / R2 / R1: set pointer, repeated START, read preset values
        m_start;
        m_wbyte(8'hA0, "R1", 1'b0);
        m_wbyte(8'h0A, "R2", 1'b0);
        m_start;
        m_wbyte(8'hA1, "R1", 1'b0);
        m_rbyte(1'b0, "R8", 8'h0A);
        m_rbyte(1'b1, "R4", 8'h0B);
        m_stop;
        check_now("R11", {7'b0, sda_pull}, 8'h00);

        // R3: write two bytes at 0x0A, then read back with the next preset byte
        m_start;
        m_wbyte(8'hA0, "R1", 1'b0);
        m_wbyte(8'h0A, "R2", 1'b0);
        m_wbyte(8'hBB, "R3", 1'b0);
        m_wbyte(8'hCC, "R3", 1'b0);
        m_stop;
        m_start;
        m_wbyte(8'hA0, "R1", 1'b0);
        m_wbyte(8'h0A, "R2", 1'b0);
        m_start;
        m_wbyte(8'hA1, "R1", 1'b0);
        m_rbyte(1'b0, "R3", 8'hBB);
        m_rbyte(1'b0, "R3", 8'hCC);
        m_rbyte(1'b1, "R4", 8'h0C);
        m_stop;

        // R1: foreign address is never acknowledged, nor its bytes
        m_start;
        m_wbyte(8'hA2, "R1", 1'b1);
        m_wbyte(8'h55, "R1", 1'b1);
        m_stop;

        // R6: wrap at 0xFF
        m_start;
        m_wbyte(8'hA0, "R1", 1'b0);
        m_wbyte(8'hFF, "R2", 1'b0);
        m_wbyte(8'h11, "R6", 1'b0);
        m_wbyte(8'h22, "R6", 1'b0);
        m_stop;
        m_start;
        m_wbyte(8'hA0, "R1", 1'b0);
        m_wbyte(8'hFF, "R2", 1'b0);
        m_start;
        m_wbyte(8'hA1, "R1", 1'b0);
        m_rbyte(1'b0, "R6", 8'h11);
        m_rbyte(1'b1, "R6", 8'h22);
        m_stop;

        // R7: after host NACK the line stays released (reads all ones)
        m_start;
        m_wbyte(8'hA0, "R1", 1'b0);
        m_wbyte(8'h20, "R2", 1'b0);
        m_start;
        m_wbyte(8'hA1, "R1", 1'b0);
        m_rbyte(1'b1, "R7", 8'h20);
        m_rbyte(1'b1, "R7", 8'hFF);
        m_stop;

        // R10 / R5: pointer-only write, new transaction reads from it
        m_start;
        m_wbyte(8'hA0, "R1", 1'b0);
        m_wbyte(8'h30, "R10", 1'b0);
        m_stop;
        m_start;
        m_wbyte(8'hA1, "R5", 1'b0);
        m_rbyte(1'b1, "R10", 8'h30);
        m_stop;

        // R9: repeated START after three bits of a data byte
        m_start;
        m_wbyte(8'hA0, "R1", 1'b0);
        m_wbyte(8'h40, "R2", 1'b0);
        m_wbit(1'b0);
        m_wbit(1'b1);
        m_wbit(1'b0);
        m_start;
        m_wbyte(8'hA1, "R9", 1'b0);
        m_rbyte(1'b1, "R9", 8'h40);
        m_stop;
        tick(4);
        check_now("R11", {7'b0, sda_pull}, 8'h00);

        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard left %0d items actual %0d expected 0", exp_q.size(), exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule